// File: doc/BRIEF.md
# Host-Controller Mailbox Register Bank

This block is a bank of 32-bit registers shared between a host bus and the internal I/O bus of an embedded controller. Each register can be reached from both buses, at a different offset on each. The bank holds four inbound queue head/tail pointer pairs and one outbound head/tail pair. It also holds a doorbell word, an outbound message word and four general scratch words. All of these words are plain storage. There is no pointer arithmetic and no full or empty tracking.

Two words have side effects when written. A write to an inbound head pointer sets a sticky bit in a four-bit inbound status register. A write to the doorbell sets a one-bit doorbell status. Both status registers are cleared by writing ones to them. Each status register has its own enable register, and the two masked results drive two interrupt lines. Each head pointer also drives a one-cycle event pulse for a performance-counter unit.

Reads are combinational from the address. Writes take effect at the rising clock edge. Status bits, event pulses and interrupt lines change one cycle after the write is presented.

Top module: `mbox_regbank`

## Requirements
- R1: After reset every register reads as zero on both buses, `head_evt` is 0, and both interrupt lines are low.
- R2: Plain words can be written and read through both buses, and a write on either bus is visible on the other bus. There are sixteen plain words. The controller offset is the host word index times 0x100, with the host word index being the byte offset divided by 4. Host byte offsets are: heads 0x4A0+4i, tails 0x4B0+4i, outbound head 0x4C8, outbound tail 0x4CC, doorbell 0x4D0, outbound message 0x4DC, scratch 0x5D0+4i. Controller offsets are: heads 0x12800+0x100i, tails 0x12C00+0x100i, outbound pair 0x13200/0x13300, doorbell 0x13400, message 0x13700, scratch 0x17400+0x100i.
- R3: A write to inbound head i, from either bus, sets bit i of the inbound status register. This register is at host 0x4C0 and controller 0x13000.
- R4: Writing ones to inbound status bits clears them. The inbound enable register is at host 0x4C4 and controller 0x13100. It stores bits 3:0 and is plain read/write. Bits 31:4 of both registers read as zero.
- R5: `inb_irq` is high exactly when some bit is set in both the inbound status and the inbound enable registers.
- R6: `head_evt[i]` is high for one cycle, in the cycle after each write to head i. Writes in back-to-back cycles give back-to-back high cycles.
- R7: A doorbell write sets doorbell status bit 0, at host 0x4D4 and controller 0x13500. Writing 1 to bit 0 clears it. The doorbell enable is bit 0 at host 0x4D8 and controller 0x13600. `bell_irq` is high when status bit 0 and enable bit 0 are both 1.
- R8: If a status bit is set and cleared in the same cycle, it ends up set.
- R9: If both buses write the same register in the same cycle, the host data is stored. Ones written to a status register by either bus clear those bits. A head written by both buses in one cycle gives a single pulse.
- R10: An unmapped or misaligned address reads as zero, and a write to it changes no register and raises no output. On the host bus this means bit 11 set, bits 1:0 nonzero, or no decode. On the controller bus it means bits 7:0 nonzero or no decode.
- R11: Writes to tails, the outbound pair, the message word or the scratch words change no status bit, pulse no event and raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_we | input | 1 | Host write strobe |
| h_addr | input | 12 | Host byte address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data (combinational) |
| c_we | input | 1 | Controller write strobe |
| c_addr | input | 17 | Controller byte address |
| c_wdata | input | 32 | Controller write data |
| c_rdata | output | 32 | Controller read data (combinational) |
| head_evt | output | 4 | One-cycle pulse per inbound head write |
| inb_irq | output | 1 | Masked inbound interrupt |
| bell_irq | output | 1 | Masked doorbell interrupt |

## Verification
Two functions can fall in the same cycle. A head or doorbell write sets a status bit. In that same cycle, a write-one from the other bus may clear the same bit. The same applies when both buses write one register. The bench provokes this with directed cycles that pair a head write on one bus with a full clear of inbound status on the other, and a scratch or head word written by both buses at once. Random cycles then choose the two addresses independently, so these collisions recur. A bench model that applies the set-wins and host-wins rules judges every read, pulse and interrupt.

// File: rtl/mbox_regbank.sv
module mbox_regbank (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_we,
  input  logic [11:0] h_addr,
  input  logic [31:0] h_wdata,
  output logic [31:0] h_rdata,
  input  logic        c_we,
  input  logic [16:0] c_addr,
  input  logic [31:0] c_wdata,
  output logic [31:0] c_rdata,
  output logic [3:0]  head_evt,
  output logic        inb_irq,
  output logic        bell_irq
);
  localparam int NW = 16;
  localparam logic [4:0] C_BELL = 5'd10, C_IST = 5'd16, C_IEN = 5'd17,
                         C_BST = 5'd18, C_BEN = 5'd19;

  // word index -> {hit, code}; codes 0..15 plain words, 16..19 status/enable
  function automatic logic [5:0] map(input logic [8:0] idx);
    case (idx)
      9'h128, 9'h129, 9'h12A, 9'h12B,
      9'h12C, 9'h12D, 9'h12E, 9'h12F: map = {1'b1, 2'b00, idx[2:0]};
      9'h130: map = {1'b1, C_IST};
      9'h131: map = {1'b1, C_IEN};
      9'h132: map = {1'b1, 5'd8};
      9'h133: map = {1'b1, 5'd9};
      9'h134: map = {1'b1, C_BELL};
      9'h135: map = {1'b1, C_BST};
      9'h136: map = {1'b1, C_BEN};
      9'h137: map = {1'b1, 5'd11};
      9'h174, 9'h175, 9'h176, 9'h177: map = {1'b1, 3'b011, idx[1:0]};
      default: map = 6'd0;
    endcase
  endfunction

  logic [31:0] word [NW];
  logic [3:0]  istat, ien;
  logic        bstat, ben;

  logic [5:0] hsel, csel;
  logic       hw, cw;
  logic [4:0] hc, cc;

  assign hsel = (!h_addr[11] && h_addr[1:0] == 2'b00) ? map(h_addr[10:2]) : 6'd0;
  assign csel = (c_addr[7:0] == 8'h00) ? map(c_addr[16:8]) : 6'd0;
  assign hc   = hsel[4:0];
  assign cc   = csel[4:0];
  assign hw   = h_we && hsel[5];
  assign cw   = c_we && csel[5];

  logic [3:0] head_wr, ist_clr;
  logic       bell_wr, bst_clr;

  for (genvar i = 0; i < 4; i++) begin : g_head
    assign head_wr[i] = (hw && hc == 5'(i)) || (cw && cc == 5'(i));
  end

  assign bell_wr = (hw && hc == C_BELL) || (cw && cc == C_BELL);
  assign ist_clr = ((hw && hc == C_IST) ? h_wdata[3:0] : 4'd0)
                 | ((cw && cc == C_IST) ? c_wdata[3:0] : 4'd0);
  assign bst_clr = (hw && hc == C_BST && h_wdata[0]) || (cw && cc == C_BST && c_wdata[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NW; k++) word[k] <= '0;
      istat    <= '0;
      ien      <= '0;
      bstat    <= 1'b0;
      ben      <= 1'b0;
      head_evt <= '0;
    end else begin
      for (int k = 0; k < NW; k++) begin
        if (hw && hc == 5'(k))      word[k] <= h_wdata;
        else if (cw && cc == 5'(k)) word[k] <= c_wdata;
      end
      istat <= (istat & ~ist_clr) | head_wr;
      bstat <= (bstat & ~bst_clr) | bell_wr;
      if (hw && hc == C_IEN)      ien <= h_wdata[3:0];
      else if (cw && cc == C_IEN) ien <= c_wdata[3:0];
      if (hw && hc == C_BEN)      ben <= h_wdata[0];
      else if (cw && cc == C_BEN) ben <= c_wdata[0];
      head_evt <= head_wr;
    end
  end

  logic [31:0] view [32];
  always_comb begin
    for (int k = 0; k < 32; k++) view[k] = '0;
    for (int k = 0; k < NW; k++) view[k] = word[k];
    view[C_IST] = {28'd0, istat};
    view[C_IEN] = {28'd0, ien};
    view[C_BST] = {31'd0, bstat};
    view[C_BEN] = {31'd0, ben};
  end

  assign h_rdata  = hsel[5] ? view[hc] : 32'd0;
  assign c_rdata  = csel[5] ? view[cc] : 32'd0;
  assign inb_irq  = |(istat & ien);
  assign bell_irq = bstat & ben;
endmodule

module mbox_regbank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        h_we,
  input logic [11:0] h_addr,
  input logic [31:0] h_rdata,
  input logic        c_we,
  input logic [16:0] c_addr,
  input logic [3:0]  head_evt,
  input logic        inb_irq,
  input logic        bell_irq,
  input logic [3:0]  istat,
  input logic [3:0]  ien,
  input logic        bstat
);
  for (genvar i = 0; i < 4; i++) begin : g_a
    AST_EVT_AFTER_HOST: assert property (@(posedge clk) disable iff (!rst_n)
      h_we && h_addr == 12'(12'h4A0 + 4*i) |=> head_evt[i]);  // R6
    AST_EVT_AFTER_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      c_we && c_addr == 17'(17'h12800 + 256*i) |=> head_evt[i]);  // R6
    AST_EVT_MEANS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      head_evt[i] |-> istat[i]);  // R8
    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      istat[i] && !(h_we && h_addr == 12'h4C0) && !(c_we && c_addr == 17'h13000) |=> istat[i]);  // R4
  end
  AST_INB_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ien == 4'd0 |-> !inb_irq);  // R5
  AST_BELL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !bstat |-> !bell_irq);  // R7
  AST_STAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    h_addr == 12'h4C0 |-> h_rdata[31:4] == 28'd0);  // R4
endmodule

bind mbox_regbank mbox_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .h_we(h_we), .h_addr(h_addr), .h_rdata(h_rdata),
  .c_we(c_we), .c_addr(c_addr), .head_evt(head_evt), .inb_irq(inb_irq),
  .bell_irq(bell_irq), .istat(istat), .ien(ien), .bstat(bstat)
);

// File: tb/mbox_regbank_test.sv
module mbox_regbank_test;
  logic clk = 0, rst_n = 0;
  logic h_we = 0, c_we = 0;
  logic [11:0] h_addr = '0;
  logic [16:0] c_addr = '0;
  logic [31:0] h_wdata = '0, c_wdata = '0, h_rdata, c_rdata;
  logic [3:0] head_evt;
  logic inb_irq, bell_irq;

  mbox_regbank uut (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  string dtag = "";

  logic [31:0] m_word [16];
  logic [3:0]  m_ist, m_ien, m_evt;
  logic        m_bst, m_ben;

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 200000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic logic [11:0] haddr(int c);
    if (c < 4)        return 12'(12'h4A0 + 4*c);
    else if (c < 8)   return 12'(12'h4B0 + 4*(c-4));
    else if (c >= 12 && c < 16) return 12'(12'h5D0 + 4*(c-12));
    case (c)
      8: return 12'h4C8;  9: return 12'h4CC; 10: return 12'h4D0; 11: return 12'h4DC;
      16: return 12'h4C0; 17: return 12'h4C4; 18: return 12'h4D4; 19: return 12'h4D8;
      default: case ($urandom % 3) 0: return 12'h4E0; 1: return 12'hCA0; default: return 12'h4A2; endcase
    endcase
  endfunction

  function automatic logic [16:0] caddr(int c);
    if (c < 4)        return 17'(17'h12800 + 256*c);
    else if (c < 8)   return 17'(17'h12C00 + 256*(c-4));
    else if (c >= 12 && c < 16) return 17'(17'h17400 + 256*(c-12));
    case (c)
      8: return 17'h13200;  9: return 17'h13300; 10: return 17'h13400; 11: return 17'h13700;
      16: return 17'h13000; 17: return 17'h13100; 18: return 17'h13500; 19: return 17'h13600;
      default: case ($urandom % 3) 0: return 17'h12840; 1: return 17'h13800; default: return 17'h17800; endcase
    endcase
  endfunction

  function automatic logic [31:0] mread(int c);
    if (c < 16) return m_word[c];
    case (c)
      16: return {28'd0, m_ist};
      17: return {28'd0, m_ien};
      18: return {31'd0, m_bst};
      19: return {31'd0, m_ben};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rtag(int c);
    if (c < 16) return "R2";
    if (c < 18) return "R4";
    if (c < 20) return "R7";
    return "R10";
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", (dtag != "") ? dtag : tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 16; k++) m_word[k] = '0;
    m_ist = '0; m_ien = '0; m_evt = '0; m_bst = 0; m_ben = 0;
  endtask

  // one cycle: drive at negedge, check reads and outputs, then update model
  task automatic step(bit hw, int hc, logic [31:0] hd, bit cw, int cc, logic [31:0] cd);
    logic [3:0] hwr, clr;
    bit bset, bclr;
    @(negedge clk);
    h_we = hw; h_addr = haddr(hc); h_wdata = hd;
    c_we = cw; c_addr = caddr(cc); c_wdata = cd;
    #1;
    if (!hw) chk(rtag(hc), h_rdata, mread(hc));
    if (!cw) chk(rtag(cc), c_rdata, mread(cc));
    chk("R6", {28'd0, head_evt}, {28'd0, m_evt});
    chk("R5", {31'd0, inb_irq}, {31'd0, |(m_ist & m_ien)});
    chk("R7", {31'd0, bell_irq}, {31'd0, m_bst & m_ben});
    hwr = '0; clr = '0;
    for (int i = 0; i < 4; i++) hwr[i] = (hw && hc == i) || (cw && cc == i);
    if (hw && hc == 16) clr |= hd[3:0];
    if (cw && cc == 16) clr |= cd[3:0];
    bset = (hw && hc == 10) || (cw && cc == 10);
    bclr = (hw && hc == 18 && hd[0]) || (cw && cc == 18 && cd[0]);
    for (int k = 0; k < 16; k++) begin
      if (hw && hc == k) m_word[k] = hd;
      else if (cw && cc == k) m_word[k] = cd;
    end
    if (hw && hc == 17) m_ien = hd[3:0]; else if (cw && cc == 17) m_ien = cd[3:0];
    if (hw && hc == 19) m_ben = hd[0];   else if (cw && cc == 19) m_ben = cd[0];
    m_ist = (m_ist & ~clr) | hwr;
    m_bst = (m_bst & ~bclr) | bset;
    m_evt = hwr;
  endtask

  task automatic idle_read_all();
    for (int c = 0; c < 20; c++) step(0, c, 0, 0, 19 - c, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    dtag = "R1";  idle_read_all();
    dtag = "R2";
    step(1, 12, 32'hDEAD_BEEF, 1, 5, 32'h1234_5678);
    step(0, 5, 0, 0, 12, 0);
    chk("R2", h_rdata, 32'h1234_5678);
    chk("R2", c_rdata, 32'hDEAD_BEEF);
    dtag = "R3";
    step(1, 2, 32'h55, 0, 0, 0);
    step(0, 16, 0, 0, 16, 0);
    chk("R3", h_rdata, 32'h4);
    step(0, 16, 0, 1, 0, 32'h9);
    dtag = "R4";
    step(1, 17, 32'hFFFF_FFFF, 0, 16, 0);
    step(0, 17, 0, 0, 16, 0);
    chk("R4", h_rdata, 32'hF);
    step(1, 16, 32'h4, 0, 0, 0);
    step(0, 16, 0, 0, 16, 0);
    chk("R4", h_rdata, 32'h1);
    dtag = "R5";
    step(0, 0, 0, 1, 17, 32'h2);
    step(0, 0, 0, 0, 0, 0);
    step(1, 1, 32'h7, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    chk("R5", {31'd0, inb_irq}, 32'd1);
    dtag = "R6";
    step(1, 3, 32'h1, 0, 0, 0);
    step(0, 0, 0, 1, 3, 32'h2);
    step(1, 0, 32'h3, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    dtag = "R7";
    step(1, 10, 32'hAB, 0, 0, 0);
    step(0, 18, 0, 1, 19, 32'h1);
    step(0, 18, 0, 0, 0, 0);
    chk("R7", {31'd0, bell_irq}, 32'd1);
    step(0, 0, 0, 1, 18, 32'h1);
    step(0, 18, 0, 0, 18, 0);
    dtag = "R8";
    step(1, 1, 32'h0, 1, 16, 32'hF);
    step(0, 16, 0, 0, 16, 0);
    chk("R8", h_rdata, 32'h2);
    step(0, 0, 0, 1, 18, 32'h1);
    step(1, 18, 32'h1, 1, 10, 32'h0);
    step(0, 18, 0, 0, 18, 0);
    chk("R8", c_rdata, 32'h1);
    dtag = "R9";
    step(1, 13, 32'hAAAA_0001, 1, 13, 32'hBBBB_0002);
    step(1, 3, 32'h11, 1, 3, 32'h22);
    step(0, 13, 0, 0, 3, 0);
    chk("R9", h_rdata, 32'hAAAA_0001);
    chk("R9", c_rdata, 32'h11);
    step(1, 16, 32'h1, 1, 16, 32'h8);
    dtag = "R10";
    for (int k = 0; k < 6; k++) step(1, 31, 32'hFFFF_FFFF, 1, 31, 32'hFFFF_FFFF);
    idle_read_all();
    dtag = "R11";
    for (int c = 4; c < 16; c++) step(1, c, $urandom, 1, (c == 10) ? 11 : c, $urandom);
    step(0, 16, 0, 0, 18, 0);
    dtag = "";

    for (int n = 0; n < 4000; n++) begin
      int hc, cc;
      hc = $urandom % 21; if (hc == 20) hc = 31;
      cc = $urandom % 21; if (cc == 20) cc = 31;
      step(($urandom % 3) != 0, hc, $urandom, ($urandom % 3) != 0, cc, $urandom);
    end
    step(0, 0, 0, 0, 0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule